// File: doc/BRIEF.md
# Break Length Meter

This block measures how long a received break (a run of zero bits) lasts on a synchronous serial line, down to a single bit. It watches the sampled data bit on each bit strobe. While a break is in progress it counts how many complete all-zero characters have gone by. It also keeps a 16-bit record of the current, unfinished character. That record is filled from its most significant bit downward. When the line returns to 1, the block writes that 1 into the record and then reports the total break length in bits, together with a one-cycle done pulse.

The total is the number of whole break characters multiplied by the character length, plus the number of leading zeros in the partial-character record. The character length is a 4-bit setting. The value 0 stands for 16 bits, and the largest usable length is 16 because the record is 16 bits wide. Baud generation, framing and the enabling of break capture by a particular line mode are handled outside the block. The block simply obeys its enable input.

Top module: `brk_len_meter`

## Requirements
- R1: After reset the character count, the pattern record and the total are all zero, and the done pulse is low.
- R2: A strobe carrying a 0 while enabled and idle starts a break. This start clears the character count and the pattern record. It leaves the previous total in place.
- R3: During a break, every run of N consecutive strobed zeros adds one to the character count. N is the value of `char_len`, and a `char_len` of 0 means N = 16. The count is updated on the clock edge that samples the N-th zero.
- R4: The character count saturates at 16'hFFFF. Further complete characters leave it at that value.
- R5: The pattern record is written starting at bit 15 and moves toward bit 0, one position per strobed bit of the current partial character. When the break ends, the record holds one 0 per zero in the partial character, then a single 1, and every bit below the 1 keeps its cleared value of 0. A record of 0b001 followed by zeros therefore means two extra zero bits.
- R6: When a whole character of zeros completes, the pattern record is cleared. A break that ends exactly on a character boundary therefore leaves the record at 16'h8000, which means no extra zero bits.
- R7: A strobed 1 during an enabled break ends the break. `brk_done` is high for exactly one cycle, on the cycle after the clock edge that samples that 1.
- R8: When `brk_done` is high, `brk_total` equals the character count multiplied by the effective character length, plus the number of leading zeros in the pattern record.
- R9: `brk_total` changes only on the edge that raises `brk_done`. It holds its value while later breaks start and while they are in progress.
- R10: While `brk_en` is low, strobes have no effect on the count or the pattern. Dropping `brk_en` during a break abandons that break without a done pulse and without changing the total.
- R11: Changes on `rx_bit` that arrive without `bit_stb` have no effect on the count, the pattern or the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | Bit sample strobe; `rx_bit` is valid when high |
| rx_bit | input | 1 | Sampled serial data bit |
| brk_en | input | 1 | Break measurement enable |
| char_len | input | 4 | Bits per character (0 means 16) |
| brk_chars | output | 16 | Whole break characters counted, saturating |
| brk_pattern | output | 16 | Partial-character record, filled from bit 15 |
| brk_total | output | 21 | Break length in bits, latched at the end of a break |
| brk_done | output | 1 | One-cycle pulse when a break ends |

## Verification
The bound checker checks these properties on every cycle:
- `brk_done` is a single-cycle pulse that only follows a terminating 1.
- The character count either holds or steps by one, except at a break start, which leaves it at most 1 and the record clear.
- The count stays pinned once it saturates.
- The total holds between done pulses.
- At every done pulse, the record holds exactly one 1, placed where the total and the count say it should be.

Only the bench's scenarios can show that the absolute values are right. That covers totals for particular lengths, including a length setting of 0, breaks ending on and between character boundaries, the 65535-character saturation run, and the fact that disabled strobes, unstrobed data and aborted breaks leave the outputs untouched.

// File: rtl/brk_len_pkg.sv
package brk_len_pkg;
  localparam int BRK_CNT_W = 16;
  localparam int BRK_PAT_W = 16;
  localparam int BRK_LEN_W = 4;

  typedef enum logic {
    BRK_IDLE = 1'b0,
    BRK_RUN  = 1'b1
  } brk_state_e;
endpackage

// File: rtl/brk_seq.sv
module brk_seq
  import brk_len_pkg::*;
#(
  parameter int POS_W = BRK_LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             brk_en,
  input  logic [POS_W-1:0] len_eff,
  output logic             start_evt,
  output logic             zero_evt,
  output logic             end_evt,
  output logic             char_done,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_ONE = 1;

  brk_state_e state_q;
  logic       take;

  assign take      = bit_stb && brk_en;
  assign start_evt = take && (state_q == BRK_IDLE) && !rx_bit;
  assign zero_evt  = take && (state_q == BRK_RUN) && !rx_bit;
  assign end_evt   = take && (state_q == BRK_RUN) && rx_bit;
  assign char_done = (start_evt || zero_evt) && (pos == len_eff - POS_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BRK_IDLE;
      pos     <= '0;
    end else if (!brk_en || end_evt) begin
      state_q <= BRK_IDLE;
      pos     <= '0;
    end else if (start_evt || zero_evt) begin
      state_q <= BRK_RUN;
      pos     <= char_done ? '0 : pos + POS_ONE;
    end
  end
endmodule

// File: rtl/brk_char_cnt.sv
module brk_char_cnt
  import brk_len_pkg::*;
#(
  parameter int CNT_W = BRK_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             zero_evt,
  input  logic             char_done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start_evt)
      cnt <= char_done ? CNT_ONE : '0;
    else if (zero_evt && char_done)
      cnt <= sat_inc(cnt);
  end
endmodule

// File: rtl/brk_pat_reg.sv
module brk_pat_reg
  import brk_len_pkg::*;
#(
  parameter int PAT_W = BRK_PAT_W,
  parameter int POS_W = BRK_LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             zero_evt,
  input  logic             end_evt,
  input  logic             char_done,
  input  logic [POS_W-1:0] pos,
  output logic [PAT_W-1:0] pat,
  output logic [PAT_W-1:0] pat_nxt
);
  localparam int IDX_W = $clog2(PAT_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(PAT_W - 1);

  logic [IDX_W-1:0] wr_idx;
  assign wr_idx = IDX_TOP - IDX_W'(pos);

  always_comb begin
    pat_nxt = pat;
    if (start_evt || (zero_evt && char_done))
      pat_nxt = '0;
    else if (zero_evt)
      pat_nxt[wr_idx] = 1'b0;
    else if (end_evt)
      pat_nxt[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pat <= '0;
    else        pat <= pat_nxt;
  end
endmodule

// File: rtl/brk_total.sv
module brk_total
  import brk_len_pkg::*;
#(
  parameter int CNT_W = BRK_CNT_W,
  parameter int PAT_W = BRK_PAT_W,
  parameter int POS_W = BRK_LEN_W + 1,
  parameter int TOT_W = BRK_CNT_W + BRK_LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             end_evt,
  input  logic [CNT_W-1:0] cnt,
  input  logic [POS_W-1:0] len_eff,
  input  logic [PAT_W-1:0] pat_nxt,
  output logic [TOT_W-1:0] total,
  output logic             done
);
  localparam int ZW = $clog2(PAT_W) + 1;
  localparam logic [ZW-1:0] Z_ONE = 1;

  // leading zeros from the top bit down to the first 1; all-zero gives PAT_W
  function automatic logic [ZW-1:0] lead_zeros(input logic [PAT_W-1:0] p);
    logic [ZW-1:0] n;
    logic          hit;
    n   = '0;
    hit = 1'b0;
    for (int i = PAT_W - 1; i >= 0; i--) begin
      if (p[i])      hit = 1'b1;
      else if (!hit) n   = n + Z_ONE;
    end
    return n;
  endfunction

  function automatic logic [TOT_W-1:0] break_bits(input logic [CNT_W-1:0] c,
                                                  input logic [POS_W-1:0] l,
                                                  input logic [PAT_W-1:0] p);
    return TOT_W'(c) * TOT_W'(l) + TOT_W'(lead_zeros(p));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      done  <= 1'b0;
    end else begin
      done <= end_evt;
      if (end_evt) total <= break_bits(cnt, len_eff, pat_nxt);
    end
  end
endmodule

// File: rtl/brk_len_meter.sv
module brk_len_meter
  import brk_len_pkg::*;
#(
  parameter  int CNT_W = BRK_CNT_W,
  parameter  int PAT_W = BRK_PAT_W,
  parameter  int LEN_W = BRK_LEN_W,
  localparam int POS_W = LEN_W + 1,
  localparam int TOT_W = CNT_W + LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             rx_bit,
  input  logic             brk_en,
  input  logic [LEN_W-1:0] char_len,
  output logic [CNT_W-1:0] brk_chars,
  output logic [PAT_W-1:0] brk_pattern,
  output logic [TOT_W-1:0] brk_total,
  output logic             brk_done
);
  localparam logic [POS_W-1:0] LEN_FULL = POS_W'(1 << LEN_W);

  logic [POS_W-1:0] len_eff;
  logic [POS_W-1:0] pos;
  logic [PAT_W-1:0] pat_nxt;
  logic             start_evt, zero_evt, end_evt, char_done;

  assign len_eff = (char_len == '0) ? LEN_FULL : POS_W'(char_len);

  brk_seq #(.POS_W(POS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .brk_en(brk_en), .len_eff(len_eff), .start_evt(start_evt),
    .zero_evt(zero_evt), .end_evt(end_evt), .char_done(char_done), .pos(pos)
  );

  brk_char_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .zero_evt(zero_evt),
    .char_done(char_done), .cnt(brk_chars)
  );

  brk_pat_reg #(.PAT_W(PAT_W), .POS_W(POS_W)) u_pat (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .zero_evt(zero_evt),
    .end_evt(end_evt), .char_done(char_done), .pos(pos),
    .pat(brk_pattern), .pat_nxt(pat_nxt)
  );

  brk_total #(.CNT_W(CNT_W), .PAT_W(PAT_W), .POS_W(POS_W), .TOT_W(TOT_W)) u_tot (
    .clk(clk), .rst_n(rst_n), .end_evt(end_evt), .cnt(brk_chars),
    .len_eff(len_eff), .pat_nxt(pat_nxt), .total(brk_total), .done(brk_done)
  );
endmodule

// File: rtl/brk_len_meter_chk.sv
module brk_len_meter_chk #(
  parameter int CNT_W = 16,
  parameter int PAT_W = 16,
  parameter int POS_W = 5,
  parameter int TOT_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             brk_en,
  input logic             start_evt,
  input logic             end_evt,
  input logic [POS_W-1:0] len_eff,
  input logic [CNT_W-1:0] brk_chars,
  input logic [PAT_W-1:0] brk_pattern,
  input logic [TOT_W-1:0] brk_total,
  input logic             brk_done
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  localparam logic [CNT_W-1:0] CONE = 1;
  localparam logic [PAT_W-1:0] PTOP = {1'b1, {(PAT_W-1){1'b0}}};

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (brk_chars <= CONE) && (brk_pattern == '0));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> (brk_chars == $past(brk_chars)) || (brk_chars == $past(brk_chars) + CONE));
  // R4
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_chars == CMAX) && !start_evt |=> brk_chars == CMAX);
  // R5
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> $countones(brk_pattern) == 1);
  // R7
  done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |=> !brk_done);
  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> $past(end_evt));
  // R8
  total_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_done |-> brk_pattern == (PTOP >> (int'(brk_total) - int'(brk_chars) * int'($past(len_eff)))));
  // R9
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_done |-> $stable(brk_total));
  // R10
  off_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_en |=> !brk_done);
endmodule

bind brk_len_meter brk_len_meter_chk #(
  .CNT_W(CNT_W), .PAT_W(PAT_W), .POS_W(POS_W), .TOT_W(TOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .brk_en(brk_en), .start_evt(start_evt),
  .end_evt(end_evt), .len_eff(len_eff), .brk_chars(brk_chars),
  .brk_pattern(brk_pattern), .brk_total(brk_total), .brk_done(brk_done)
);

// File: tb/brk_len_meter_bench.sv
module brk_len_meter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_stb = 1'b0;
  logic        rx_bit = 1'b1;
  logic        brk_en = 1'b1;
  logic [3:0]  char_len = 4'd8;
  logic [15:0] brk_chars;
  logic [15:0] brk_pattern;
  logic [20:0] brk_total;
  logic        brk_done;

  int checks = 0;
  int failures = 0;
  logic [52:0] exp_q[$];
  logic prev_done = 1'b0;

  always #5 clk = ~clk;

  brk_len_meter u_brk_len_meter (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .brk_en(brk_en), .char_len(char_len), .brk_chars(brk_chars),
    .brk_pattern(brk_pattern), .brk_total(brk_total), .brk_done(brk_done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_zeros(input int n);
    @(negedge clk); rx_bit = 1'b0; bit_stb = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); bit_stb = 1'b0;
  endtask

  task automatic send_one();
    @(negedge clk); rx_bit = 1'b1; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0;
  endtask

  // driver: expected outcome from R3..R8 arithmetic
  task automatic run_break(input logic [3:0] len, input int nz);
    int l, z, c;
    char_len = len;
    l = (len == 0) ? 16 : int'(len);
    c = nz / l;
    if (c > 65535) c = 65535;
    z = nz % l;
    exp_q.push_back({16'(c), 16'(16'h8000 >> z), 21'(c * l + z)});
    send_zeros(nz);
    send_one();
    repeat (3) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (brk_done && prev_done) check(1'b0, "R7 done wider than one cycle", 1, 0);
      if (brk_done) begin
        if (exp_q.size() == 0) check(1'b0, "R7/R10/R11 unexpected done", 1, 0);
        else begin
          logic [52:0] e;
          e = exp_q.pop_front();
          check(brk_chars == e[52:37], "R3/R4 char count", brk_chars, e[52:37]);
          check(brk_pattern == e[36:21], "R5/R6 pattern", brk_pattern, e[36:21]);
          check(brk_total == e[20:0], "R8 total", brk_total, e[20:0]);
        end
      end
      prev_done <= brk_done;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(brk_chars == 0, "R1 count", brk_chars, 0);
    check(brk_pattern == 0, "R1 pattern", brk_pattern, 0);
    check(brk_total == 0 && !brk_done, "R1 total/done", brk_total, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_break(4'd8, 3);    // R5 partial only
    run_break(4'd10, 25);  // R3 two chars plus five
    run_break(4'd7, 14);   // R6 ends on boundary
    run_break(4'd0, 40);   // R3 length 0 means 16
    run_break(4'd5, 1);    // R5 single zero
    run_break(4'd1, 3);    // R6 one-bit characters

    // R10: strobes while disabled leave count and pattern alone
    brk_en = 1'b0;
    send_zeros(5);
    check(brk_chars == 3, "R10 count while disabled", brk_chars, 3);
    check(brk_pattern == 16'h8000, "R10 pattern while disabled", brk_pattern, 16'h8000);
    brk_en = 1'b1;

    // R2 / R9: new break clears count and record, total held
    char_len = 4'd12;
    send_zeros(1);
    check(brk_chars == 0, "R2 count cleared", brk_chars, 0);
    check(brk_pattern == 0, "R2 pattern cleared", brk_pattern, 0);
    check(brk_total == 3, "R9 total held at new break", brk_total, 3);

    // R11: data moves without strobe
    @(negedge clk); rx_bit = 1'b1;
    repeat (4) @(negedge clk);
    rx_bit = 1'b0;
    @(negedge clk);
    check(brk_chars == 0 && !brk_done, "R11 unstrobed data ignored", brk_chars, 0);

    // R3 live count: eleven more zeros complete a twelve-bit character
    send_zeros(11);
    check(brk_chars == 1, "R3 live count", brk_chars, 1);
    check(brk_total == 3, "R9 total held mid-break", brk_total, 3);

    // R10: abort by dropping enable, then a 1 gives no done
    @(negedge clk); brk_en = 1'b0;
    @(negedge clk); brk_en = 1'b1;
    send_one();
    repeat (3) @(negedge clk);
    check(brk_total == 3, "R10 abort keeps total", brk_total, 3);

    // R4 saturation
    run_break(4'd1, 65540);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 missing done pulses", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule